// File: doc/BRIEF.md
# Cascaded Serial Input Expander Controller

This block reads a chain of `NUM_DEV` cascaded 8-bit parallel-in, serial-out shift registers over three wires and delivers the result as one `NUM_DEV*8`-bit word. It drives an active-low capture strobe (`ld_n_o`), a shift clock (`sclk_o`) and a clock-inhibit line (`inh_o`), and it reads the chain through a single serial data input (`sdata_i`).

A one-cycle `start_i` pulse begins a read. The controller takes the strobe low so that every register in the chain captures its parallel inputs. It then raises the strobe again and waits out the setup window. Next it runs `NUM_DEV*8` shift-clock periods. In the last system cycle before each rising shift edge it samples the data line. The first bit appears on the line straight after capture, with no clock edge, so the first sample catches it. Every later rising edge moves the chain on by one bit, and bits from the far registers pass through the nearer ones.

The minimum times are given as nanosecond parameters: capture pulse width, strobe-to-first-edge setup, clock high time, clock low time and clock period. Each is rounded up to whole system-clock cycles. With the defaults (20 ns system clock, 2 registers) every phase lasts 2 cycles, and a full read takes 69 cycles from the cycle after `start_i` to the end of the `done_o` cycle.

The state machine has six states. IDLE (strobe high, clock low, inhibit high) moves to LOAD when `start_i` is seen. LOAD (strobe low, inhibit low) moves to SETUP when the capture timer expires. SETUP (strobe high, clock low) moves to LOW when the setup timer expires. LOW moves to HIGH when the low timer expires, and the data line is sampled on that transition. HIGH moves back to LOW when the high timer expires with bits still to go, or to DONE after the last bit. DONE lasts one cycle with `done_o` high and then returns to IDLE.

Top module: `serial_in_expander`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the block returns to IDLE: `ld_n_o`=1, `sclk_o`=0, `inh_o`=1, `busy_o`=0, `done_o`=0. This holds even in the middle of a read.
- R2: A `start_i` seen in IDLE drives `ld_n_o` low for exactly LOAD_CYC = ceil(LOAD_MIN_NS*1000/SYS_PERIOD_PS) cycles (2 by default). During that time `sclk_o` stays low and `inh_o` is low.
- R3: After `ld_n_o` rises, `sclk_o` stays low for exactly SETUP_CYC + LO_CYC cycles before its first rising edge (4 by default).
- R4: Each read has exactly `NUM_DEV*8` rising edges on `sclk_o`. Every high phase lasts HI_CYC = ceil(HIGH_MIN_NS) cycles. Every low phase between edges lasts LO_CYC, which is the larger of ceil(LOW_MIN_NS) and ceil(PERIOD_MIN_NS) minus HI_CYC (2 and 2 by default). `sclk_o` is high only while `ld_n_o`=1 and `inh_o`=0.
- R5: `sdata_i` is sampled in the last cycle of each low phase, before the edge. The first sample goes to `word_o` bit `NUM_DEV*8-1` and the last to bit 0. So with the chain's host-facing stage taken as the top bit, `word_o` equals the captured parallel inputs.
- R6: `done_o` is high for exactly one cycle, in the cycle after the last high phase, with the complete word on `word_o`. `word_o` then stays unchanged while the block is idle.
- R7: A `start_i` seen while `busy_o`=1 is ignored. The current read goes on with the same edge count, word and single `done_o`.
- R8: After DONE the block is back in IDLE: `inh_o`=1, `sclk_o`=0, `ld_n_o`=1 and `busy_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request a read of the chain |
| sdata_i | input | 1 | Serial data from the chain |
| ld_n_o | output | 1 | Capture strobe, low captures the parallel inputs |
| sclk_o | output | 1 | Shift clock to the chain |
| inh_o | output | 1 | Clock inhibit, high while idle |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle pulse when the word is ready |
| word_o | output | NUM_DEV*8 | Assembled word, first bit at the top |

## Verification
A wrong state or timer value shows up at the pins within one phase (two cycles by default). It appears as a strobe pulse, setup gap, high time or low time whose length differs from the required count. A wrong bit counter shows up as a rising-edge count other than `NUM_DEV*8`, and the misplaced `done_o` makes that visible by the end of the read. A sampling slip of even one cycle shifts or corrupts `word_o` at the `done_o` cycle. The bench uses patterns chosen so that every bit position and both edges of the word tell such a slip apart from a correct read.

// File: rtl/sie_pkg.sv
package sie_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_DONE
    } sie_state_e;

    // Round a nanosecond minimum up to whole system cycles, at least one.
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/sie_phase_timer.sv
module sie_phase_timer #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);

    // R4: an expired timer stays expired until it is reloaded
    a_r4_timer_parks: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !load_i) |=> expired_o);

endmodule

// File: rtl/sie_bit_counter.sv
module sie_bit_counter #(
    parameter int unsigned NBITS = 16,
    localparam int unsigned CW = $clog2(NBITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic inc_i,
    output logic last_o
);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear_i) begin
            count_q <= '0;
        end else if (inc_i) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign last_o = (count_q == CW'(NBITS));

    // R4: never more samples than bits in the chain
    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(NBITS));

    // R4: no sample is taken once the last bit is in
    a_r4_no_extra_sample: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !clear_i) |-> !inc_i);

endmodule

// File: rtl/sie_word_assembler.sv
module sie_word_assembler #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (shift_i) begin
            word_q <= {word_q[WORD_W-2:0], bit_i};
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/serial_in_expander.sv
module serial_in_expander
    import sie_pkg::*;
#(
    parameter int unsigned NUM_DEV       = 2,
    parameter int unsigned SYS_PERIOD_PS = 20000,
    parameter int unsigned LOAD_MIN_NS   = 25,
    parameter int unsigned SETUP_MIN_NS  = 25,
    parameter int unsigned HIGH_MIN_NS   = 23,
    parameter int unsigned LOW_MIN_NS    = 23,
    parameter int unsigned PERIOD_MIN_NS = 40
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   sdata_i,
    output logic                   ld_n_o,
    output logic                   sclk_o,
    output logic                   inh_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic [NUM_DEV*8-1:0]   word_o
);

    localparam int unsigned WORD_W    = NUM_DEV * 8;
    localparam int unsigned LOAD_CYC  = ns_to_cyc(LOAD_MIN_NS, SYS_PERIOD_PS);
    localparam int unsigned SETUP_CYC = ns_to_cyc(SETUP_MIN_NS, SYS_PERIOD_PS);
    localparam int unsigned HI_CYC    = ns_to_cyc(HIGH_MIN_NS, SYS_PERIOD_PS);
    localparam int unsigned LO_RAW    = ns_to_cyc(LOW_MIN_NS, SYS_PERIOD_PS);
    localparam int unsigned PER_CYC   = ns_to_cyc(PERIOD_MIN_NS, SYS_PERIOD_PS);
    localparam int unsigned LO_CYC    = (PER_CYC > HI_CYC + LO_RAW) ? (PER_CYC - HI_CYC) : LO_RAW;
    localparam int unsigned MAX_AB    = (LOAD_CYC > SETUP_CYC) ? LOAD_CYC : SETUP_CYC;
    localparam int unsigned MAX_CD    = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
    localparam int unsigned MAX_CYC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int unsigned TMR_W     = $clog2(MAX_CYC + 1);

    sie_state_e state_q, state_d;
    logic             tmr_load, tmr_zero, bit_last, sample, clear_cnt;
    logic [TMR_W-1:0] tmr_val;

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- transitions ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)  state_d = ST_LOAD;
            ST_LOAD:  if (tmr_zero) state_d = ST_SETUP;
            ST_SETUP: if (tmr_zero) state_d = ST_LOW;
            ST_LOW:   if (tmr_zero) state_d = ST_HIGH;
            ST_HIGH:  if (tmr_zero) state_d = bit_last ? ST_DONE : ST_LOW;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- phase lengths ----------------
    always_comb begin
        unique case (state_d)
            ST_LOAD:  tmr_val = TMR_W'(LOAD_CYC - 1);
            ST_SETUP: tmr_val = TMR_W'(SETUP_CYC - 1);
            ST_LOW:   tmr_val = TMR_W'(LO_CYC - 1);
            ST_HIGH:  tmr_val = TMR_W'(HI_CYC - 1);
            default:  tmr_val = '0;
        endcase
    end

    assign tmr_load  = (state_d != state_q);
    assign sample    = (state_q == ST_LOW) && tmr_zero;
    assign clear_cnt = (state_q == ST_IDLE) && start_i;

    // ---------------- outputs ----------------
    always_comb begin
        ld_n_o = 1'b1;
        sclk_o = 1'b0;
        inh_o  = 1'b0;
        busy_o = 1'b1;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                inh_o  = 1'b1;
                busy_o = 1'b0;
            end
            ST_LOAD:  ld_n_o = 1'b0;
            ST_SETUP: ;
            ST_LOW:   ;
            ST_HIGH:  sclk_o = 1'b1;
            ST_DONE: begin
                inh_o  = 1'b1;
                done_o = 1'b1;
            end
            default: begin
                inh_o  = 1'b1;
                busy_o = 1'b0;
            end
        endcase
    end

    // ---------------- datapath ----------------
    sie_phase_timer #(.CNT_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .expired_o  (tmr_zero)
    );

    sie_bit_counter #(.NBITS(WORD_W)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_cnt),
        .inc_i   (sample),
        .last_o  (bit_last)
    );

    sie_word_assembler #(.WORD_W(WORD_W)) u_word (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (sample),
        .bit_i   (sdata_i),
        .word_o  (word_o)
    );

    // ---------------- checks ----------------
    logic [TMR_W:0] hi_run_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run_q <= '0;
        end else if (sclk_o) begin
            hi_run_q <= hi_run_q + 1'b1;
        end else begin
            hi_run_q <= '0;
        end
    end

    // R4: every high phase is at least HI_CYC long
    a_r4_high_width: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_o && hi_run_q != '0) |-> (hi_run_q >= (TMR_W+1)'(HI_CYC)));

    // R4: shift edges only with the strobe high and inhibit low
    a_r4_clock_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> (ld_n_o && !inh_o));

    // R2: capture keeps the clock low and inhibit released
    a_r2_quiet_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_n_o |-> (!sclk_o && !inh_o));

    // R3: the clock is still low when the strobe returns high
    a_r3_no_edge_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ld_n_o) |-> !sclk_o);

    // R6: done is a single-cycle pulse
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: the word is frozen while idle
    a_r6_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(word_o));

    // R7: a running read is not abandoned before done
    a_r7_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

// File: tb/serial_in_expander_tb_top.sv
module serial_in_expander_tb_top;

    localparam int unsigned NDEV = 2;
    localparam int unsigned W    = NDEV * 8;
    localparam int EXP_LOAD = 2;
    localparam int EXP_GAP  = 4;
    localparam int EXP_HI   = 2;
    localparam int EXP_LO   = 2;
    localparam int NVEC     = 6;

    // stimulus pattern (upper half) and expected word (lower half)
    localparam logic [2*W-1:0] VEC [NVEC] = '{
        {16'h0000, 16'h0000},
        {16'hFFFF, 16'hFFFF},
        {16'hA5C3, 16'hA5C3},
        {16'h8001, 16'h8001},
        {16'h1234, 16'h1234},
        {16'h7FFE, 16'h7FFE}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] par = '0;
    logic [W-1:0] chain = '0;
    logic         sdata, ld_n, sclk, inh, busy, done;
    logic [W-1:0] word;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    serial_in_expander #(.NUM_DEV(NDEV)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .sdata_i (sdata),
        .ld_n_o  (ld_n),
        .sclk_o  (sclk),
        .inh_o   (inh),
        .busy_o  (busy),
        .done_o  (done),
        .word_o  (word)
    );

    // model of the cascaded register chain, host-facing stage at the top
    always @(posedge sclk or negedge ld_n) begin
        if (!ld_n) chain <= par;
        else if (!inh) chain <= {chain[W-2:0], 1'b0};
    end
    assign sdata = chain[W-1];

    // ---------------- pin monitor ----------------
    int m_ld, m_gap, m_rise, m_hmin, m_hmax, m_lmin, m_lmax, m_done, hi_run, lo_run;
    bit gap_run, ld_p, sclk_p;

    task automatic mon_clear();
        m_ld = 0; m_gap = 0; m_rise = 0; m_done = 0;
        m_hmin = 9999; m_hmax = 0; m_lmin = 9999; m_lmax = 0;
        hi_run = 0; lo_run = 0; gap_run = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (!ld_n) m_ld++;
            if (ld_n && !ld_p) begin gap_run = 1; m_gap = 0; end
            if (gap_run) begin
                if (!sclk) m_gap++;
                else gap_run = 0;
            end
            if (sclk && !sclk_p) begin
                if (m_rise > 0) begin
                    if (lo_run < m_lmin) m_lmin = lo_run;
                    if (lo_run > m_lmax) m_lmax = lo_run;
                end
                lo_run = 0;
                m_rise++;
            end
            if (sclk) hi_run++;
            else if (sclk_p) begin
                if (hi_run < m_hmin) m_hmin = hi_run;
                if (hi_run > m_hmax) m_hmax = hi_run;
                hi_run = 0;
            end
            if (!sclk && m_rise > 0 && busy) lo_run++;
            if (done) m_done++;
        end
        ld_p   = ld_n;
        sclk_p = sclk;
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic chk_word(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk("R6 done seen", int'(done), 1);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic check_timing(input string tag);
        chk({tag, " R2 load width"}, m_ld, EXP_LOAD);
        chk({tag, " R3 setup gap"}, m_gap, EXP_GAP);
        chk({tag, " R4 rise count"}, m_rise, W);
        chk({tag, " R4 high min"}, m_hmin, EXP_HI);
        chk({tag, " R4 high max"}, m_hmax, EXP_HI);
        chk({tag, " R4 low min"}, m_lmin, EXP_LO);
        chk({tag, " R4 low max"}, m_lmax, EXP_LO);
        chk({tag, " R6 done count"}, m_done, 1);
    endtask

    task automatic check_idle(input string req);
        chk({req, " ld_n"}, int'(ld_n), 1);
        chk({req, " sclk"}, int'(sclk), 0);
        chk({req, " inh"},  int'(inh), 1);
        chk({req, " busy"}, int'(busy), 0);
        chk({req, " done"}, int'(done), 0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R6 act=running exp=finished");
        finish_run();
    end

    // ---------------- main sequence ----------------
    initial begin
        mon_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 reset state");

        // table walk: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < NVEC; i++) begin
            @(posedge clk);
            par = VEC[i][2*W-1:W];
            mon_clear();
            pulse_start();
            wait_done();
            chk_word("R5 R6 word at done", word, VEC[i][W-1:0]);
            repeat (3) @(negedge clk);
            check_timing("vec");
            check_idle("R8 after done");
        end

        // R6: word held while idle even if the inputs change
        @(posedge clk);
        par = 16'h5A5A;
        repeat (20) @(negedge clk);
        chk_word("R6 word hold", word, 16'h7FFE);
        chk("R6 no stray done", m_done, 1);

        // R7: start during a read is ignored
        @(posedge clk);
        par = 16'hC00C;
        mon_clear();
        pulse_start();
        repeat (10) @(negedge clk);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk("R7 still busy", int'(busy), 1);
        wait_done();
        chk_word("R7 word unaffected", word, 16'hC00C);
        repeat (3) @(negedge clk);
        check_timing("R7");
        repeat (20) @(negedge clk);
        chk("R7 no second read", m_ld, EXP_LOAD);

        // R1: reset in the middle of a read
        @(posedge clk);
        par = 16'h0F0F;
        pulse_start();
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_idle("R1 mid-read reset");
        chk_word("R1 word cleared", word, '0);

        // R5: read after reset recovers cleanly
        @(posedge clk);
        mon_clear();
        pulse_start();
        wait_done();
        chk_word("R5 read after reset", word, 16'h0F0F);

        finish_run();
    end

endmodule